// File: doc/BRIEF.md
# Conversion-ready SPI sample reader

This block reads samples from an external 24-bit converter over SPI without any help from a processor. The converter tells the block that a new result is ready by pulling an active-low ready line low. The block passes that line through a synchroniser and acts only on its falling edge. Each edge starts one SPI burst of three bytes. Every received byte is clocked in by shifting out a configurable dummy byte on MOSI.

The three received bytes are joined into a 24-bit word, most significant byte first. The word is offered to a downstream writer on a valid/ready handshake and is held there until the writer accepts it. A new burst starts only when the SPI side is idle and the previous word has been taken. A ready edge that arrives at any other time is dropped and sets a sticky overrun flag. When no conversion is ready the SPI clock stays still, so the converter never sees stray clocks between results.

The divider setting gives SPI half periods of `cfg_div + 1` system clocks. It is expected to stay constant while a burst is running.

Top module: `adc_spi_reader`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low, `smp_valid` is low and `overrun` is low.
- R2: A burst starts only after a high-to-low transition of `adc_rdy_n`. A level held low, however long, gives exactly one burst.
- R3: SPI mode 0 is used. `sclk` idles low, MISO is sampled on the rising edge, MOSI changes only while `sclk` is low, and every `sclk` high or low phase lasts `cfg_div + 1` system clocks.
- R4: `cs_n` falls `cfg_div + 1` system clocks before the first rising edge of `sclk`. It rises `cfg_div + 1` system clocks after the last falling edge.
- R5: Each burst has exactly 24 rising `sclk` edges. The value `cfg_dummy` is sent for each of the three bytes, MSB first.
- R6: The output word is {first byte, second byte, third byte}, each byte MSB first. It becomes valid on the same clock edge at which `cs_n` rises.
- R7: While `smp_valid` is high and `smp_ready` is low, `smp_valid` stays high and `smp_data` does not change.
- R8: A ready edge that arrives during a burst, or while an output word is waiting, starts no burst and leaves the pending word unchanged. It sets `overrun`, which stays high until reset.
- R9: `sclk` is low at all times while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_rdy_n | input | 1 | Converter result-ready line, active low, asynchronous |
| cfg_dummy | input | 8 | Byte shifted out on MOSI for each received byte |
| cfg_div | input | DIV_W (8) | Half-period of SCLK minus one, in system clocks |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | 1 | SPI chip select, active low |
| smp_valid | output | 1 | Output word valid |
| smp_ready | input | 1 | Downstream accepts the word |
| smp_data | output | 24 | Assembled sample |
| overrun | output | 1 | Sticky flag: a ready edge was dropped |

## Verification
The hardest situations to reach are the dropped ready edges of R8. One must land in the middle of a burst. The other must arrive while a finished word is still held by a stalled consumer. The bench reaches the first by releasing and re-asserting the ready line a fixed number of cycles after a burst has begun, well inside its known length. It reaches the second by keeping `smp_ready` low after a word appears and then producing another edge. In both cases it checks that no extra chip-select cycle occurs, that the held word does not change, and that `overrun` stays high until the next reset. A behavioural converter model answers on MISO, and every SCLK and chip-select edge is timed against `cfg_div + 1` for several divider settings.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_TRAIL = 2'd2
  } rd_state_t;
endpackage

// File: rtl/adc_rd_sync.sv
// Two-stage synchroniser for the ready pin plus a falling-edge detector.
module adc_rd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [2:0] sr_q;
  logic [2:0] sr_d;

  always_comb sr_d = {sr_q[1:0], pin_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 3'b111;
    else        sr_q <= sr_d;
  end

  assign fall = sr_q[2] & ~sr_q[1];
endmodule

// File: rtl/adc_rd_shift.sv
// One-byte mode-0 shift engine. A new byte can be accepted in the cycle
// of the final falling edge so that consecutive bytes run without a gap.
module adc_rd_shift #(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              load,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              last_fall,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BIT_CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [BIT_CW-1:0] bit_q, bit_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              half_end;
  logic              accept;

  assign half_end  = busy_q && (cnt_q == div);
  assign last_fall = half_end && sclk_q && (bit_q == LAST_BIT);
  assign accept    = load && (!busy_q || last_fall);

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (busy_q) begin
      if (half_end) begin
        cnt_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[BYTE_W-2:0], miso};
        end else begin
          sclk_d = 1'b0;
          if (bit_q == LAST_BIT) begin
            busy_d = 1'b0;
          end else begin
            bit_d = bit_q + 1'b1;
            tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (accept) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      cnt_d  = '0;
      bit_d  = '0;
      tx_d   = tx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[BYTE_W-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/adc_rd_pack.sv
// Joins received bytes, first byte most significant, and holds the word
// on a valid/ready output.
module adc_rd_pack #(
  parameter int BYTE_W       = 8,
  parameter int SAMPLE_BYTES = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_vld,
  input  logic [BYTE_W-1:0]          byte_in,
  input  logic                       commit,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [BYTE_W*SAMPLE_BYTES-1:0] out_data
);
  localparam int SAMPLE_W = BYTE_W * SAMPLE_BYTES;

  logic [SAMPLE_W-1:0] acc_q, acc_d;
  logic [SAMPLE_W-1:0] word_q, word_d;
  logic                vld_q, vld_d;

  generate
    if (SAMPLE_BYTES > 1) begin : g_multi
      always_comb acc_d = byte_vld ? {acc_q[SAMPLE_W-BYTE_W-1:0], byte_in} : acc_q;
    end else begin : g_single
      always_comb acc_d = byte_vld ? byte_in : acc_q;
    end
  endgenerate

  always_comb begin
    word_d = word_q;
    vld_d  = vld_q;
    if (commit) begin
      word_d = acc_q;
      vld_d  = 1'b1;
    end else if (vld_q && out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = word_q;
endmodule

// File: rtl/adc_spi_reader.sv
module adc_spi_reader #(
  parameter int DIV_W        = 8,
  parameter int SAMPLE_BYTES = 3,
  parameter int BYTE_W       = 8,
  parameter int SAMPLE_W     = BYTE_W * SAMPLE_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adc_rdy_n,
  input  logic [BYTE_W-1:0]   cfg_dummy,
  input  logic [DIV_W-1:0]    cfg_div,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                cs_n,
  output logic                smp_valid,
  input  logic                smp_ready,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                overrun
);
  import adc_rd_pkg::*;

  localparam int BCW = (SAMPLE_BYTES > 1) ? $clog2(SAMPLE_BYTES) : 1;
  localparam logic [BCW-1:0] LAST_BYTE = BCW'(SAMPLE_BYTES - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sr_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_int_n = rst_sr_q[1];

  logic              trig;
  logic              load;
  logic              last_fall;
  logic              commit;
  logic [BYTE_W-1:0] rx_byte;

  rd_state_t         state_q, state_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [BCW-1:0]    byte_q, byte_d;
  logic              cs_q, cs_d;
  logic              ovr_q, ovr_d;

  adc_rd_sync u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin_n (adc_rdy_n),
    .fall  (trig)
  );

  adc_rd_shift #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .div       (cfg_div),
    .load      (load),
    .tx_byte   (cfg_dummy),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .last_fall (last_fall),
    .rx_byte   (rx_byte)
  );

  adc_rd_pack #(.BYTE_W(BYTE_W), .SAMPLE_BYTES(SAMPLE_BYTES)) u_pack (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .byte_vld  (last_fall),
    .byte_in   (rx_byte),
    .commit    (commit),
    .out_ready (smp_ready),
    .out_valid (smp_valid),
    .out_data  (smp_data)
  );

  assign commit = (state_q == ST_TRAIL) && (cnt_q == cfg_div);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    byte_d  = byte_q;
    cs_d    = cs_q;
    load    = 1'b0;
    ovr_d   = ovr_q | (trig && ((state_q != ST_IDLE) || smp_valid));
    case (state_q)
      ST_IDLE: begin
        if (trig && !smp_valid) begin
          load    = 1'b1;
          cs_d    = 1'b0;
          byte_d  = '0;
          state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (last_fall) begin
          if (byte_q == LAST_BYTE) begin
            cnt_d   = '0;
            state_d = ST_TRAIL;
          end else begin
            load   = 1'b1;
            byte_d = byte_q + 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (commit) begin
          cs_d    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      byte_q  <= '0;
      cs_q    <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      cs_q    <= cs_d;
      ovr_q   <= ovr_d;
    end
  end

  assign cs_n    = cs_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n,
  input logic                sclk,
  input logic                mosi,
  input logic                smp_valid,
  input logic                smp_ready,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic                overrun
);
  AST_NO_CLK_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R9

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R3

  AST_VALID_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> $rose(cs_n)); // R6

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data))); // R7

  AST_NO_BURST_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(smp_valid)); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8
endmodule

bind adc_spi_reader adc_rd_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .smp_data  (smp_data),
  .overrun   (overrun)
);

// File: tb/adc_spi_reader_tb.sv
`timescale 1ns/1ps
module adc_spi_reader_tb;
  localparam int DIV_W = 8;
  localparam int SW    = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          adc_rdy_n = 1'b1;
  logic [7:0]    cfg_dummy = 8'h00;
  logic [DIV_W-1:0] cfg_div = '0;
  logic          sclk, mosi, cs_n, smp_valid, overrun;
  logic          miso = 1'b0;
  logic          smp_ready = 1'b0;
  logic [SW-1:0] smp_data;

  always #10 clk = ~clk;

  adc_spi_reader u_dut (
    .clk(clk), .rst_n(rst_n), .adc_rdy_n(adc_rdy_n), .cfg_dummy(cfg_dummy),
    .cfg_div(cfg_div), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .overrun(overrun)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural converter and reference model
  logic [SW-1:0] adc_word = '0;
  logic [SW-1:0] adc_sh = '0;
  logic [SW-1:0] exp_q[$];
  int bursts = 0;
  int got = 0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_vld = 1'b0, p_rdy = 1'b0;
  logic [SW-1:0] p_data = '0;
  int cyc = 0;
  int nrise = 0;
  logic [SW-1:0] mosi_word = '0;

  always @(negedge clk) begin
    int h;
    h = int'(cfg_div) + 1;
    if (cs_n) chk(!sclk, "R9", "sclk while deselected", sclk, 0);
    if (p_cs && !cs_n) begin
      bursts++;
      nrise = 0;
      cyc = 0;
      adc_sh = adc_word;
      miso = adc_sh[SW-1];
    end else if (!p_cs) begin
      cyc++;
      if (cs_n) begin
        chk(cyc == h, "R4", "sclk fall to cs rise", cyc, h);
        chk(nrise == SW, "R5", "rising edges per burst", nrise, SW);
        chk(mosi_word == {3{cfg_dummy}}, "R5", "mosi bits", mosi_word, {3{cfg_dummy}});
        cyc = 0;
      end else if (sclk != p_sclk) begin
        if (sclk && nrise == 0) chk(cyc == h, "R4", "cs fall to first sclk rise", cyc, h);
        else                    chk(cyc == h, "R3", "sclk half period", cyc, h);
        cyc = 0;
        if (sclk) begin
          mosi_word = {mosi_word[SW-2:0], mosi};
          nrise++;
        end else begin
          adc_sh = adc_sh << 1;
          miso = adc_sh[SW-1];
        end
      end
    end
    if (p_vld && !p_rdy)
      chk(smp_valid && smp_data == p_data, "R7", "held word", smp_data, p_data);
    if (smp_valid && smp_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8", "unexpected word", smp_data, 0);
      end else begin
        logic [SW-1:0] e;
        e = exp_q.pop_front();
        chk(smp_data == e, "R6", "assembled word", smp_data, e);
      end
      got++;
    end
    p_sclk = sclk; p_cs = cs_n; p_vld = smp_valid; p_rdy = smp_ready; p_data = smp_data;
  end

  // ---------------- stimulus helpers
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic fire(input logic [SW-1:0] w, input int hold, input bit expect_burst);
    adc_word = w;
    if (expect_burst) exp_q.push_back(w);
    step(1);
    adc_rdy_n = 1'b0;
    step(hold);
    adc_rdy_n = 1'b1;
  endtask

  task automatic wait_got(input int n, input string req);
    int t;
    t = 0;
    while (got < n && t < 5000) begin step(1); t++; end
    chk(got >= n, req, "words received", got, n);
  endtask

  task automatic wait_valid(input string req);
    int t;
    t = 0;
    while (!smp_valid && t < 5000) begin step(1); t++; end
    chk(smp_valid, req, "word appeared", smp_valid, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    chk(smp_valid == 1'b0, "R1", "valid after reset", smp_valid, 0);
    chk(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);
  endtask

  initial begin
    int b0;
    #2;
    do_reset();

    // T1: fastest divider, consumer always ready
    cfg_div = 8'd0; cfg_dummy = 8'hA5; smp_ready = 1'b1;
    fire(24'h123456, 4, 1);
    wait_got(1, "R6");
    chk(bursts == 1, "R2", "bursts after one edge", bursts, 1);

    // T2: stalled consumer, divider 3
    cfg_div = 8'd3; cfg_dummy = 8'h3C; smp_ready = 1'b0;
    fire(24'hA5F00F, 3, 1);
    wait_valid("R6");
    step(20);
    chk(smp_data == 24'hA5F00F, "R7", "word while stalled", smp_data, 24'hA5F00F);
    smp_ready = 1'b1;
    wait_got(2, "R7");

    // T3: ready line held low far longer than a burst
    cfg_div = 8'd1; cfg_dummy = 8'hFF;
    b0 = bursts;
    fire(24'h800001, 400, 1);
    step(50);
    chk(bursts == b0 + 1, "R2", "bursts for long low level", bursts, b0 + 1);
    chk(overrun == 1'b0, "R2", "no overrun for long level", overrun, 0);
    wait_got(3, "R2");

    // T4: second edge in the middle of a burst
    cfg_div = 8'd2; cfg_dummy = 8'h00;
    b0 = bursts;
    fire(24'h7E81C3, 3, 1);
    step(20);
    fire(24'h000000, 3, 0);
    adc_word = 24'h7E81C3;
    wait_got(4, "R8");
    step(30);
    chk(overrun == 1'b1, "R8", "overrun after edge in burst", overrun, 1);
    chk(bursts == b0 + 1, "R8", "bursts with dropped edge", bursts, b0 + 1);

    do_reset();

    // T5: edge while a word is pending
    cfg_div = 8'd0; cfg_dummy = 8'h5A; smp_ready = 1'b0;
    b0 = bursts;
    fire(24'hFEDCBA, 3, 1);
    wait_valid("R6");
    fire(24'h111111, 3, 0);
    step(60);
    chk(overrun == 1'b1, "R8", "overrun with word pending", overrun, 1);
    chk(bursts == b0 + 1, "R8", "bursts with word pending", bursts, b0 + 1);
    chk(smp_data == 24'hFEDCBA, "R8", "pending word kept", smp_data, 24'hFEDCBA);
    smp_ready = 1'b1;
    wait_got(got + 1, "R8");

    // T6: several conversions, divider 5
    cfg_div = 8'd5; cfg_dummy = 8'hC3;
    for (int k = 0; k < 4; k++) begin
      int g;
      g = got;
      fire(24'h0F0F0F ^ (24'h135797 * (k + 1)), 3, 1);
      wait_got(g + 1, "R6");
      step(5);
    end
    chk(exp_q.size() == 0, "R6", "expected words left", exp_q.size(), 0);
    chk(overrun == 1'b1, "R8", "overrun still set", overrun, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule